// File: doc/BRIEF.md
# Sticky Level Interrupt Requester

This block turns a raw peripheral event into an active-low, level-sensitive interrupt request for a processor. The raw event is first synchronised into the clock domain. Its rising edge then sets a request latch, but only while the enable bit is on. Once the latch is set, the interrupt line stays low until the service routine writes an explicit clear command. Turning the enable off stops new events from setting the latch. It never pulls back a request that is already on the line. A processor that sees a request disappear before it can acknowledge it would take a spurious-interrupt trap, so this rule is the point of the block.

Software reaches the block through a small register port. Register 0 holds the enable. Register 1 takes the clear command. Register 2 reads back the latch and the enable. When the processor runs an acknowledge cycle at this block's priority level, the block drives an active-low autovector select instead of placing a vector on the data bus. The interrupt pin and the select both come straight from flip-flops.

Top module: `irq_requester`

## Requirements
- R1: While reset is asserted and right after it, `irq_n` and `avec_n` are high, the request latch is clear and the enable is 0, so the status register reads 0.
- R2: With the enable set, a rising edge on `evt_raw` that is driven just after clock edge 0 drives `irq_n` low at clock edge 3. This delay is two synchroniser stages plus one edge-detect stage. `irq_n` is still high between edges 2 and 3.
- R3: One rising edge of `evt_raw` sets the latch at most once. If `evt_raw` stays high after a clear, the request is not raised again.
- R4: The enable is bit 0 of register address 0. A rising edge of `evt_raw` while the enable is 0 is ignored. It is not remembered, so setting the enable later does not raise `irq_n`.
- R5: Writing 0 to the enable while a request is pending leaves `irq_n` low.
- R6: A write to address 1 with bit 0 set releases `irq_n` at that clock edge. A write to address 1 with bit 0 clear has no effect. No other path raises `irq_n`.
- R7: When a latch-set event and a clear write fall on the same edge, the set wins and `irq_n` stays low.
- R8: `rdata` is combinational from `addr`:
  - Address 2 returns the latch in bit 0 and the enable in bit 1.
  - Address 0 returns the enable in bit 0.
  - Address 1 reads as 0.
- R9: `avec_n` goes low one edge after a cycle in which `ack_strobe` is high, `ack_level` equals `IRQ_LEVEL` (6 by default) and the latch is set. It returns high one edge after `ack_strobe` falls. A level that does not match leaves it high.
- R10: An acknowledge cycle at the matching level while no request is pending leaves `avec_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_raw | input | 1 | Raw asynchronous event from the peripheral |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Register read data (combinational) |
| ack_strobe | input | 1 | Processor interrupt-acknowledge cycle active |
| ack_level | input | LVL_W | Priority level being acknowledged |
| irq_n | output | 1 | Active-low level interrupt request, registered |
| avec_n | output | 1 | Active-low autovector select, registered |

## Verification
The bench times the event path edge by edge. A synchroniser that is one stage short, or an output gated combinationally, would move the falling edge of `irq_n` off edge 3. It holds `evt_raw` high across a clear: a level-triggered set would raise the request again at once. It turns the enable off while a request is pending and lines a clear write up with the set pulse. Gating the output pin with the enable would withdraw the request, and a clear-priority latch would lose the event. It also acknowledges at a wrong level and with no request pending, which catches a select that ignores the level or the latch.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  // Latch next state: a new event outranks a clear in the same cycle.
  function automatic logic latch_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Rising edge of a synchronised level against its previous value.
  function automatic logic rise_of(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic pulse
);
  import irq_req_pkg::*;
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[LAST];

  assign pulse = rise_of(chain[LAST], prev);
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_cmd,
  output logic pending,
  output logic irq_n
);
  import irq_req_pkg::*;
  logic nxt;

  always_comb nxt = latch_next(pending, set_evt, clr_cmd);

  // The pin register is loaded from the same next state as the latch,
  // so the line never passes through gating after a flop.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pending <= 1'b0;
      irq_n   <= 1'b1;
    end else begin
      pending <= nxt;
      irq_n   <= ~nxt;
    end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port #(
  parameter int DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [irq_req_pkg::ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]               wdata,
  input  logic                            pending,
  output logic                            enable,
  output logic                            clr_cmd,
  output logic [DATA_W-1:0]               rdata
);
  import irq_req_pkg::*;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          enable <= 1'b0;
    else if (wr_en && addr == ADDR_CTRL) enable <= wdata[0];

  assign clr_cmd = wr_en && (addr == ADDR_CLR) && wdata[0];

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_CTRL: rdata[0] = enable;
      ADDR_STAT: begin
        rdata[0] = pending;
        rdata[1] = enable;
      end
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_ack_decode.sv
module irq_ack_decode #(
  parameter int LVL_W     = 3,
  parameter int IRQ_LEVEL = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_strobe,
  input  logic [LVL_W-1:0] ack_level,
  input  logic             pending,
  output logic             ack_hit,
  output logic             avec_n
);
  localparam logic [LVL_W-1:0] MY_LEVEL = LVL_W'(IRQ_LEVEL);

  assign ack_hit = ack_strobe && (ack_level == MY_LEVEL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) avec_n <= 1'b1;
    else        avec_n <= ~(ack_hit && pending);
endmodule

// File: rtl/irq_requester.sv
module irq_requester #(
  parameter int DATA_W      = 8,
  parameter int LVL_W       = 3,
  parameter int IRQ_LEVEL   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           evt_raw,
  input  logic                           wr_en,
  input  logic [irq_req_pkg::ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  input  logic                           ack_strobe,
  input  logic [LVL_W-1:0]               ack_level,
  output logic                           irq_n,
  output logic                           avec_n
);
  logic evt_pulse, set_evt, clr_cmd, pending, enable, ack_hit;

  irq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(evt_raw), .pulse(evt_pulse));

  // Enable qualifies only the set path of the latch.
  assign set_evt = evt_pulse & enable;

  irq_req_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_cmd(clr_cmd),
    .pending(pending), .irq_n(irq_n));

  irq_reg_port #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pending(pending), .enable(enable), .clr_cmd(clr_cmd), .rdata(rdata));

  irq_ack_decode #(.LVL_W(LVL_W), .IRQ_LEVEL(IRQ_LEVEL)) u_ack (
    .clk(clk), .rst_n(rst_n), .ack_strobe(ack_strobe), .ack_level(ack_level),
    .pending(pending), .ack_hit(ack_hit), .avec_n(avec_n));
endmodule

// File: rtl/irq_requester_chk.sv
module irq_requester_chk (
  input logic clk,
  input logic rst_n,
  input logic irq_n,
  input logic avec_n,
  input logic ack_strobe,
  input logic ack_hit,
  input logic pending,
  input logic enable,
  input logic set_evt,
  input logic clr_cmd,
  input logic evt_pulse
);
  assert_fall_needs_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(set_evt));
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |=> !evt_pulse);
  assert_disabled_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && !enable) |=> irq_n);
  assert_hold_without_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !clr_cmd) |=> !irq_n);
  assert_rise_needs_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(clr_cmd && !set_evt));
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && clr_cmd) |=> !irq_n);
  assert_avec_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !avec_n |-> $past(ack_hit && pending));
  assert_avec_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_strobe |=> avec_n);
endmodule

bind irq_requester irq_requester_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .avec_n(avec_n),
  .ack_strobe(ack_strobe), .ack_hit(ack_hit), .pending(pending),
  .enable(enable), .set_evt(set_evt), .clr_cmd(clr_cmd), .evt_pulse(evt_pulse));

// File: tb/tb_irq_requester.sv
module tb_irq_requester;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       evt_raw = 0;
  logic       wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       ack_strobe = 0;
  logic [2:0] ack_level = 0;
  logic       irq_n, avec_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    int         kind;   // 0 irq_n, 1 avec_n, 2 rdata
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];
  item_t cur;
  logic [7:0] act;

  always #5 clk = ~clk;

  irq_requester dut (
    .clk(clk), .rst_n(rst_n), .evt_raw(evt_raw), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ack_strobe(ack_strobe), .ack_level(ack_level),
    .irq_n(irq_n), .avec_n(avec_n));

  // Monitor: compares queued expectations at the falling edge.
  always @(negedge clk) begin
    if (q.size() != 0) begin
      cur = q.pop_front();
      case (cur.kind)
        0:       act = {7'd0, irq_n};
        1:       act = {7'd0, avec_n};
        default: act = rdata;
      endcase
      checks++;
      if (act !== cur.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", cur.tag, act, cur.exp);
      end
    end
  end

  task automatic expect_item(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    expect_item(2, exp, tag);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    tick(1);
    wr_en = 0; wdata = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(2);
    expect_item(0, 8'h01, "R1 irq_n in reset");
    expect_rd(2'd2, 8'h00, "R1 status in reset");
    rst_n = 1;
    tick(1);
    expect_item(0, 8'h01, "R1 irq_n after reset");
    expect_item(1, 8'h01, "R1 avec_n after reset");

    // R4: event while disabled is dropped
    evt_raw = 1;
    tick(4);
    expect_item(0, 8'h01, "R4 event ignored when disabled");
    wr(2'd0, 8'h01);
    tick(3);
    expect_item(0, 8'h01, "R4 not remembered after enable");
    expect_rd(2'd2, 8'h02, "R8 status enable only");
    expect_rd(2'd0, 8'h01, "R8 ctrl readback");
    evt_raw = 0;
    tick(3);

    // R2: exact latency
    evt_raw = 1;
    tick(2);
    expect_item(0, 8'h01, "R2 still high before edge 3");
    tick(1);
    expect_item(0, 8'h00, "R2 low at edge 3");
    expect_rd(2'd2, 8'h03, "R8 status pending+enable");

    // R6 clear, R3 no re-set while held high
    wr(2'd1, 8'h01);
    expect_item(0, 8'h01, "R6 clear releases");
    tick(4);
    expect_item(0, 8'h01, "R3 held level does not reassert");
    evt_raw = 0;
    tick(3);

    // R5: disabling keeps pending request
    evt_raw = 1;
    tick(4);
    expect_item(0, 8'h00, "R5 request set");
    wr(2'd0, 8'h00);
    tick(3);
    expect_item(0, 8'h00, "R5 still low after disable");
    expect_rd(2'd2, 8'h01, "R8 status pending only");
    expect_rd(2'd1, 8'h00, "R8 clear reg reads zero");

    // R9: acknowledge decode
    ack_level = 3'd5; ack_strobe = 1;
    tick(2);
    expect_item(1, 8'h01, "R9 wrong level no select");
    ack_level = 3'd6;
    tick(1);
    expect_item(1, 8'h00, "R9 select asserted");
    ack_strobe = 0;
    tick(1);
    expect_item(1, 8'h01, "R9 select released");
    expect_item(0, 8'h00, "R6 ack does not release");

    // R6: clear with bit0 = 0 is no clear
    wr(2'd1, 8'h00);
    expect_item(0, 8'h00, "R6 clear bit0=0 ignored");
    wr(2'd1, 8'h01);
    expect_item(0, 8'h01, "R6 clear releases again");

    // R10: ack with nothing pending
    ack_strobe = 1;
    tick(2);
    expect_item(1, 8'h01, "R10 no select when idle");
    ack_strobe = 0;

    // R7: set and clear on the same edge
    wr(2'd0, 8'h01);
    evt_raw = 0;
    tick(3);
    evt_raw = 1;
    tick(2);
    wr_en = 1; addr = 2'd1; wdata = 8'h01;
    tick(1);
    wr_en = 0; wdata = 0;
    expect_item(0, 8'h00, "R7 set wins over clear");
    expect_rd(2'd2, 8'h03, "R7 status pending");

    // R1: reset while pending
    rst_n = 0;
    tick(1);
    expect_item(0, 8'h01, "R1 reset drops request");
    expect_rd(2'd2, 8'h00, "R1 reset clears status");
    rst_n = 1;
    tick(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule